// File: doc/BRIEF.md
# Four-Phase Instruction Pipeline Sequencer

This block sets the instruction flow of a small microcontroller core whose instructions are 16 bits wide. Each instruction cycle is four clock periods long, Q1 to Q4. While the instruction held in the instruction register is decoded and executed, the next word is read from a byte-addressed program memory. The sequencer drives the fetch address, latches the instruction register and raises the data memory read and write strobes in their fixed phases. An external decoder may ask it to load a new program counter or to skip the next instruction. In either case the word already fetched is discarded and that cycle runs as a NOP.

The sequencer tells two-word instructions apart from their opcode bits, and it marks the cycle that carries the second word. A word whose top nibble is all ones runs as a NOP when it is reached without a first word ahead of it. A status output labels every instruction cycle, so that cycles can be counted per instruction class.

Top module: `qseq_top`

## Requirements
- R1: The phase output is one-hot and steps through bit 0 (Q1), bit 1 (Q2), bit 2 (Q3) and bit 3 (Q4), then returns to bit 0. One instruction cycle is therefore exactly four clocks.
- R2: While the synchronous reset `rst` is high, and in the first cycle after it, the phase is Q1, the fetch address is 0, the instruction register holds the NOP word 16'h0000 and the cycle kind is FLUSH. Cycle kind encodings: EXEC=0, FLUSH=1, WORD2=2, ORPHAN=3.
- R3: `pmAddr` stays constant for a whole instruction cycle and moves on at the clock edge that starts the next Q1. It moves by +2 unless a load is taken. Bit 0 is always 0. The memory word is {byte at odd address, byte at even address}.
- R4: The word present on `pmData` at the end of Q4 is latched into `irWord` at that edge. It is held unchanged for the next four clocks, in which it executes. The cycle kind changes only at that same edge.
- R5: `dmRead` is high only in Q2 and `dmWrite` only in Q4, and each only in EXEC cycles.
- R6: `pcLoad` is sampled in Q4 of an EXEC or WORD2 cycle. When it is taken, the next fetch address is `pcTarget` with bit 0 cleared, and the next cycle is FLUSH with `irWord` = 16'h0000.
- R7: `skipReq` is sampled in the same way. The fetched word is discarded (next cycle FLUSH, NOP) and the address steps by +2. If both requests are high, `pcLoad` wins.
- R8: A word whose bits [15:12] are 4'hC, or whose bits [15:10] are 6'b111011, is a two-word first word. When it runs in an EXEC cycle, the next cycle is WORD2 and carries the following word, whatever its bits are.
- R9: A word whose bits [15:12] are 4'hF, reached outside a WORD2 position, runs in an ORPHAN cycle. No data strobes are raised in that cycle.
- R10: `pcLoad` and `skipReq` are ignored in Q1 to Q3 and in FLUSH and ORPHAN cycles. The fetch address then follows the +2 rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous reset, active high |
| pmAddr | output | PC_W | program memory byte address |
| pmData | input | 16 | program memory word at pmAddr |
| pcLoad | input | 1 | take a new program counter (sampled in Q4) |
| pcTarget | input | PC_W | target byte address for pcLoad |
| skipReq | input | 1 | discard the next instruction (sampled in Q4) |
| irWord | output | 16 | instruction register |
| phaseHot | output | 4 | one-hot phase Q1..Q4 |
| dmRead | output | 1 | data memory operand read strobe |
| dmWrite | output | 1 | data memory destination write strobe |
| cycleKind | output | 2 | kind of the current instruction cycle |

## Verification
Assertions watch on every cycle that the phase wraps and steps, that the program counter and instruction register hold inside a cycle, and that the counter steps by two when no load is taken. They also check that a flush leaves a NOP, that the write strobe follows the read strobe of the same cycle and that WORD2 cycles never come in pairs. Some behaviour only the scenarios can show: branch targets with an odd low bit, a skip over a two-word first word that leaves its tail as an ORPHAN, a two-word branch taking three cycles, a load and a skip raised together, and noise on the request inputs being ignored. The bench compares all of these against a cycle reference model.

// File: rtl/qseq_pkg.sv
package qseq_pkg;

  localparam int INSTR_W     = 16;
  localparam int PHASE_COUNT = 4;
  localparam int READ_PHASE  = 1;
  localparam int WRITE_PHASE = PHASE_COUNT - 1;
  localparam logic [INSTR_W-1:0] NOP_WORD = '0;

  typedef enum logic [1:0] {
    KIND_EXEC   = 2'd0,
    KIND_FLUSH  = 2'd1,
    KIND_WORD2  = 2'd2,
    KIND_ORPHAN = 2'd3
  } cycle_kind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latch;  // instruction-cycle boundary (end of Q4)
    logic flush;  // discard the fetched word
    logic jump;   // load the program counter from the target
  } seq_strobe_t;

  // opcode class flags from datapath to control
  typedef struct packed {
    logic irFirst;    // instruction register holds a two-word first word
    logic fetchTail;  // fetched word has an all-ones top nibble
  } seq_flags_t;

  function automatic logic isFirstWord(input logic [INSTR_W-1:0] w);
    return (w[15:12] == 4'hC) || (w[15:10] == 6'b111011);
  endfunction

  function automatic logic isTailWord(input logic [INSTR_W-1:0] w);
    return w[15:12] == 4'hF;
  endfunction

endpackage

// File: rtl/qseq_ctrl.sv
module qseq_ctrl
  import qseq_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   pcLoad,
  input  logic                   skipReq,
  input  seq_flags_t             flags,
  output seq_strobe_t            strobe,
  output logic [PHASE_COUNT-1:0] phaseHot,
  output cycle_kind_e            kind,
  output logic                   dmRead,
  output logic                   dmWrite
);

  localparam int PH_W = $clog2(PHASE_COUNT);
  localparam logic [PH_W-1:0] LAST_Q = PH_W'(PHASE_COUNT - 1);

  logic [PH_W-1:0] qCnt;
  logic            lastPhase;
  logic            active;
  cycle_kind_e     nextKind;

  assign lastPhase = (qCnt == LAST_Q);
  assign active    = (kind == KIND_EXEC) || (kind == KIND_WORD2);

  for (genvar g = 0; g < PHASE_COUNT; g++) begin : gPhase
    assign phaseHot[g] = (qCnt == PH_W'(g));
  end

  always_comb begin
    strobe.latch = lastPhase;
    strobe.jump  = lastPhase && active && pcLoad;
    strobe.flush = lastPhase && active && (pcLoad || skipReq);
  end

  always_comb begin
    if (active && (pcLoad || skipReq))
      nextKind = KIND_FLUSH;
    else if ((kind == KIND_EXEC) && flags.irFirst)
      nextKind = KIND_WORD2;
    else if (flags.fetchTail)
      nextKind = KIND_ORPHAN;
    else
      nextKind = KIND_EXEC;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      qCnt <= '0;
      kind <= KIND_FLUSH;
    end else begin
      qCnt <= lastPhase ? '0 : PH_W'(qCnt + 1'b1);
      if (lastPhase) kind <= nextKind;
    end
  end

  assign dmRead  = (kind == KIND_EXEC) && phaseHot[READ_PHASE];
  assign dmWrite = (kind == KIND_EXEC) && phaseHot[WRITE_PHASE];

  assert_phase_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    (qCnt == LAST_Q) |=> (qCnt == '0));

  assert_phase_step_R1: assert property (@(posedge clk) disable iff (rst)
    (qCnt != LAST_Q) |=> (qCnt == PH_W'($past(qCnt) + 1'b1)));

  assert_kind_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !lastPhase |=> $stable(kind));

  assert_write_after_read_R5: assert property (@(posedge clk) disable iff (rst)
    dmWrite |-> $past(dmRead, 2));

  assert_single_word2_R8: assert property (@(posedge clk) disable iff (rst)
    (lastPhase && kind == KIND_WORD2) |=> (kind != KIND_WORD2));

endmodule

// File: rtl/qseq_datapath.sv
module qseq_datapath
  import qseq_pkg::*;
#(
  parameter int PC_W = 21
) (
  input  logic               clk,
  input  logic               rst,
  input  seq_strobe_t        strobe,
  input  logic [PC_W-1:0]    pcTarget,
  input  logic [INSTR_W-1:0] fetchWord,
  output logic [PC_W-1:0]    pmAddr,
  output logic [INSTR_W-1:0] irWord,
  output seq_flags_t         flags
);

  localparam logic [PC_W-1:0] WORD_STEP = PC_W'(2);

  logic [PC_W-1:0]    pcReg;
  logic [INSTR_W-1:0] irReg;
  logic [PC_W-1:0]    pcNext;

  always_comb begin
    if (strobe.jump) pcNext = {pcTarget[PC_W-1:1], 1'b0};
    else             pcNext = pcReg + WORD_STEP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pcReg <= '0;
      irReg <= NOP_WORD;
    end else if (strobe.latch) begin
      pcReg <= pcNext;
      irReg <= strobe.flush ? NOP_WORD : fetchWord;
    end
  end

  assign pmAddr          = pcReg;
  assign irWord          = irReg;
  assign flags.irFirst   = isFirstWord(irReg);
  assign flags.fetchTail = isTailWord(fetchWord);

  assert_pc_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !strobe.latch |=> $stable(pcReg));

  assert_pc_step_R3: assert property (@(posedge clk) disable iff (rst)
    (strobe.latch && !strobe.jump) |=> (pcReg == $past(pcReg) + WORD_STEP));

  assert_ir_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !strobe.latch |=> $stable(irReg));

  assert_flush_nop_R6: assert property (@(posedge clk) disable iff (rst)
    strobe.flush |=> (irReg == NOP_WORD));

endmodule

// File: rtl/qseq_top.sv
module qseq_top
  import qseq_pkg::*;
#(
  parameter int PC_W = 21
) (
  input  logic                   clk,
  input  logic                   rst,
  output logic [PC_W-1:0]        pmAddr,
  input  logic [INSTR_W-1:0]     pmData,
  input  logic                   pcLoad,
  input  logic [PC_W-1:0]        pcTarget,
  input  logic                   skipReq,
  output logic [INSTR_W-1:0]     irWord,
  output logic [PHASE_COUNT-1:0] phaseHot,
  output logic                   dmRead,
  output logic                   dmWrite,
  output logic [1:0]             cycleKind
);

  seq_strobe_t strobe;
  seq_flags_t  flags;
  cycle_kind_e kind;

  qseq_ctrl uCtrl (
    .clk      (clk),
    .rst      (rst),
    .pcLoad   (pcLoad),
    .skipReq  (skipReq),
    .flags    (flags),
    .strobe   (strobe),
    .phaseHot (phaseHot),
    .kind     (kind),
    .dmRead   (dmRead),
    .dmWrite  (dmWrite)
  );

  qseq_datapath #(.PC_W(PC_W)) uPath (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .pcTarget  (pcTarget),
    .fetchWord (pmData),
    .pmAddr    (pmAddr),
    .irWord    (irWord),
    .flags     (flags)
  );

  assign cycleKind = kind;

endmodule

// File: tb/qseq_top_test.sv
`timescale 1ns/1ps
module qseq_top_test;

  localparam int PC_W   = 21;
  localparam int NCLK   = 1600;
  localparam int PC_MSK = (1 << PC_W) - 1;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [PC_W-1:0] pmAddr;
  logic [15:0]     pmData;
  logic            pcLoad = 1'b0;
  logic [PC_W-1:0] pcTarget = '0;
  logic            skipReq = 1'b0;
  logic [15:0]     irWord;
  logic [3:0]      phaseHot;
  logic            dmRead, dmWrite;
  logic [1:0]      cycleKind;

  always #2 clk = ~clk;

  qseq_top #(.PC_W(PC_W)) uut (
    .clk(clk), .rst(rst), .pmAddr(pmAddr), .pmData(pmData),
    .pcLoad(pcLoad), .pcTarget(pcTarget), .skipReq(skipReq),
    .irWord(irWord), .phaseHot(phaseHot), .dmRead(dmRead),
    .dmWrite(dmWrite), .cycleKind(cycleKind)
  );

  // byte-wide program memory, low byte at the even address
  logic [7:0] progMem [0:127];
  assign pmData = {progMem[{pmAddr[6:1], 1'b1}], progMem[{pmAddr[6:1], 1'b0}]};

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  int kindSeen [4];
  int bothSeen = 0;

  // reference model state
  int mPhase, mPc, mIr, mKind, mPrevIr;

  function automatic int memWord(input int a);
    int b;
    b = a & 126;
    return {progMem[b + 1], progMem[b]};
  endfunction

  task automatic putWord(input int idx, input int w);
    progMem[2*idx]     = w[7:0];
    progMem[2*idx + 1] = w[15:8];
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      mPhase = 0; mPc = 0; mIr = 0; mKind = 1; mPrevIr = 0;
    end else if (mPhase != 3) begin
      mPhase++;
    end else begin
      int w, nk;
      bit act;
      w   = memWord(mPc);
      act = (mKind == 0) || (mKind == 2);
      mPrevIr = mIr;
      if (act && pcLoad) begin
        mPc = (int'(pcTarget) & ~1) & PC_MSK; nk = 1; mIr = 0;
      end else if (act && skipReq) begin
        mPc = (mPc + 2) & PC_MSK; nk = 1; mIr = 0;
      end else begin
        if (mKind == 0 && ((mIr[15:12] == 4'hC) || (mIr[15:10] == 6'b111011))) nk = 2;
        else if (w[15:12] == 4'hF) nk = 3;
        else nk = 0;
        mIr = w; mPc = (mPc + 2) & PC_MSK;
      end
      mKind  = nk;
      mPhase = 0;
    end
  end

  task automatic compareAll();
    chk(phaseHot == 4'(1 << mPhase), "R1", "phaseHot", phaseHot, 1 << mPhase);
    chk(int'(pmAddr) == mPc, "R3/R6/R7/R10", "pmAddr", pmAddr, mPc);
    chk(int'(irWord) == mIr, "R4", "irWord", irWord, mIr);
    chk(int'(cycleKind) == mKind, "R6/R7/R8/R9", "cycleKind", cycleKind, mKind);
    chk(dmRead == (mKind == 0 && mPhase == 1), "R5", "dmRead", dmRead, (mKind == 0 && mPhase == 1));
    chk(dmWrite == (mKind == 0 && mPhase == 3), "R5", "dmWrite", dmWrite, (mKind == 0 && mPhase == 3));
    if (mPhase == 0) kindSeen[cycleKind]++;
  endtask

  // external decoder plus request noise, driven from the model state
  task automatic drive();
    pcLoad = 1'b0; skipReq = 1'b0; pcTarget = PC_W'($urandom_range(0, 127));
    if (mPhase != 3) begin
      // R10: requests outside Q4 must be ignored
      pcLoad  = ($urandom_range(0, 2) == 0);
      skipReq = ($urandom_range(0, 2) == 0);
    end else if (mKind == 1 || mKind == 3) begin
      // R10: requests in FLUSH or ORPHAN cycles must be ignored
      pcLoad  = $urandom_range(0, 1);
      skipReq = $urandom_range(0, 1);
    end else if (mKind == 0 && mIr[15:12] == 4'hD) begin
      pcLoad   = 1'b1;
      pcTarget = PC_W'((mIr & 255) * 2 + 1);  // odd on purpose: R6 bit 0 cleared
      skipReq  = $urandom_range(0, 1);       // R7: load wins
      if (skipReq) bothSeen++;
    end else if (mKind == 0 && mIr[15:12] == 4'hB) begin
      skipReq = 1'b1;
    end else if (mKind == 2 && mPrevIr[15:8] == 8'hEF) begin
      pcLoad   = 1'b1;
      pcTarget = PC_W'((mIr & 255) * 2 + 1);
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) putWord(i, 16'h6666);
    putWord(0, 16'h1234);  putWord(1, 16'h2A01);
    putWord(2, 16'hC005);  putWord(3, 16'hF123);   // R8 two-word
    putWord(4, 16'hF0AA);                          // R9 orphan
    putWord(5, 16'hB000);  putWord(6, 16'h3333);   // R7 skip
    putWord(7, 16'hB000);  putWord(8, 16'hEC10);   // skip a first word
    putWord(9, 16'hF014);                          // its tail becomes orphan
    putWord(10, 16'hD00E); putWord(11, 16'h4444);  // R6 branch to word 14
    putWord(14, 16'hEF10); putWord(15, 16'hF014);  // two-word branch to word 20
    putWord(20, 16'h7000); putWord(21, 16'hEC00);
    putWord(22, 16'h8000);                         // WORD2 without F nibble
    putWord(23, 16'hD000);                         // branch back to word 0

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R2: state while reset is held
    chk(pmAddr == '0, "R2", "pmAddr in reset", pmAddr, 0);
    chk(irWord == 16'h0000, "R2", "irWord in reset", irWord, 0);
    chk(phaseHot == 4'b0001, "R2", "phase in reset", phaseHot, 1);
    rst = 1'b0;
    @(negedge clk);
    // R2: first cycle after reset
    chk(cycleKind == 2'd1, "R2", "first kind", cycleKind, 1);
    chk(!dmRead && !dmWrite, "R2", "strobes after reset", {dmRead, dmWrite}, 0);
    chk(phaseHot == 4'b0010, "R1", "phase after one clock", phaseHot, 2);
    drive();
    for (int c = 0; c < NCLK; c++) begin
      @(negedge clk);
      compareAll();
      drive();
    end
    chk(kindSeen[0] > 0, "R4", "EXEC cycles seen", kindSeen[0], 1);
    chk(kindSeen[1] > 0, "R6", "FLUSH cycles seen", kindSeen[1], 1);
    chk(kindSeen[2] > 0, "R8", "WORD2 cycles seen", kindSeen[2], 1);
    chk(kindSeen[3] > 0, "R9", "ORPHAN cycles seen", kindSeen[3], 1);
    chk(bothSeen > 0, "R7", "load with skip seen", bothSeen, 1);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule